// File: doc/BRIEF.md
# Input Level-Change Interrupt Unit

This block watches a bank of input lines and raises one interrupt when any enabled line changes level. Each line is brought into the clock domain through a two-stage synchronizer. A per-line choice then passes either the synchronized level or a debounced level to the change detector. The detector compares each clocked sample with the one taken a cycle earlier. A difference latches that line's pending flag, whether or not the line is armed. The interrupt output is the OR of the pending flags of the armed lines.

Software drives the unit through a small word-addressed register port. It arms lines by writing ones to a set register and disarms them by writing ones to a clear register. It chooses the debounce path per line and reads the current line levels. One read of the pending register returns every pending flag and empties the register in the same access. If a new change lands in the cycle of that read, it is kept. The block has no notion of how a line is used elsewhere in the chip, so detection runs on every line at all times.

Top module: `pin_change_irq`

## Requirements
- R1: After reset the arm mask, the debounce select and the pending flags are all zero and `irqOut` is low. Lines that are already high while reset is held do not produce a pending flag once reset is released.
- R2: A write to word address 0 (arm-set) ORs the written data into the arm mask. Zero bits leave their mask bits unchanged. The mask reads back at word address 2.
- R3: A write to word address 1 (arm-clear) clears every mask bit written as one. Zero bits leave their mask bits unchanged.
- R4: A level change on a line that is not debounced sets that line's pending flag on the second clock edge after the edge that first samples the new level, whether or not the line is armed.
- R5: `irqOut` is high exactly when some line has both its pending flag and its mask bit set.
- R6: A read of word address 3 (pending) returns all pending flags on `busRdata` in the cycle of the read. At the following edge it clears all of them.
- R7: A change detected at the same edge as a pending read leaves that line's flag set after the read. The read returns only the flags that existed before the change.
- R8: Word address 4 (debounce select, read/write) routes a line through a debounce stage when its bit is 1. On such a line a level must hold for STABLE_CLKS consecutive sampled cycles before it is passed on. Shorter pulses produce no pending flag, and a passed change is flagged STABLE_CLKS edges later than on a plain line.
- R9: A read of word address 5 returns, for each line, the level that feeds the change detector: the synchronized level, or the debounced level where the line's debounce select bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; detection needs it running |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | LINES | Asynchronous input lines |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address of the register |
| busWdata | input | LINES | Write data |
| busRdata | output | LINES | Read data, valid in the access cycle |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a pending read that lands on the very edge where a fresh change is detected. The stimulus toggles one line on a falling edge, counts two rising edges through the synchronizer, and issues the read in the third cycle. It then checks two things: the read returns only the older flag, and a second read finds the new one. Debounce rejection is reached the same way, with pulses one cycle shorter than the hold time and exactly equal to it. Random steps of line levels, arm masks and debounce selects surround these directed cases. A bench model accumulates the expected pending flags between the random reads.

// File: rtl/pci_pkg.sv
package pci_pkg;

  // Depth of the input synchronizer and the warm-up it implies.
  localparam int SYNC_STAGES = 2;
  localparam int WARM_CYC    = SYNC_STAGES + 1;
  localparam int REG_AW      = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_ARM_SET  = 3'd0,
    REG_ARM_CLR  = 3'd1,
    REG_ARM_MASK = 3'd2,
    REG_PENDING  = 3'd3,
    REG_FILT_SEL = 3'd4,
    REG_PIN_LVL  = 3'd5
  } regIdx_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    armSetWr;
    logic    armClrWr;
    logic    filtWr;
    logic    statusRd;
    logic    detectEn;
    regIdx_e rdIdx;
  } ctrlStrobes_t;

endpackage

// File: rtl/pci_glitch_filter.sv
module pci_glitch_filter #(
  parameter int STABLE_CLKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic rawIn,
  output logic fltOut
);
  localparam int CNT_W = $clog2(STABLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CLKS - 1);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fltOut <= 1'b0;
      runCnt <= '0;
    end else if (load) begin
      fltOut <= rawIn;
      runCnt <= '0;
    end else if (rawIn == fltOut) begin
      runCnt <= '0;
    end else if (runCnt == LAST) begin
      fltOut <= rawIn;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R8: an input that agrees with the output never moves the output
  p_filter_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!load && rawIn == fltOut) |=> $stable(fltOut));

  // R8: the run counter never passes the hold length
  p_filter_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= LAST);

endmodule

// File: rtl/pci_ctrl.sv
module pci_ctrl
  import pci_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [REG_AW-1:0]    busAddr,
  output ctrlStrobes_t         strb
);
  localparam int WARM_W = $clog2(WARM_CYC + 1);
  localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(WARM_CYC);

  logic [WARM_W-1:0] warmCnt;
  logic              wrHit;
  logic              rdHit;
  regIdx_e           addrIdx;

  // Detection stays off until the synchronizer and the previous sample hold real data.
  always_ff @(posedge clk) begin
    if (!rstN)                 warmCnt <= '0;
    else if (warmCnt != WARM_DONE) warmCnt <= warmCnt + 1'b1;
  end

  always_comb begin
    addrIdx       = regIdx_e'(busAddr);
    wrHit         = busSel && busWrite;
    rdHit         = busSel && !busWrite;
    strb          = '0;
    strb.detectEn = (warmCnt == WARM_DONE);
    strb.rdIdx    = addrIdx;
    strb.armSetWr = wrHit && (addrIdx == REG_ARM_SET);
    strb.armClrWr = wrHit && (addrIdx == REG_ARM_CLR);
    strb.filtWr   = wrHit && (addrIdx == REG_FILT_SEL);
    strb.statusRd = rdHit && (addrIdx == REG_PENDING);
  end

  // R1: detection once enabled stays enabled until reset
  p_detect_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.detectEn |=> strb.detectEn);

  // R6: a write never produces the clearing read strobe
  p_no_clear_on_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> !strb.statusRd);

endmodule

// File: rtl/pci_datapath.sv
module pci_datapath
  import pci_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int STABLE_CLKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] pinIn,
  input  logic [LINES-1:0] wdata,
  input  ctrlStrobes_t     strb,
  output logic [LINES-1:0] rdata,
  output logic             irqOut
);
  logic [LINES-1:0] syncA, syncB, fltLvl, sample, prevSample;
  logic [LINES-1:0] change, pending, armMask, filtSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_filt
    pci_glitch_filter #(.STABLE_CLKS(STABLE_CLKS)) u_filt (
      .clk   (clk),
      .rstN  (rstN),
      .load  (!strb.detectEn),
      .rawIn (syncB[i]),
      .fltOut(fltLvl[i])
    );
  end

  always_comb begin
    sample = (fltLvl & filtSel) | (syncB & ~filtSel);
    change = strb.detectEn ? (sample ^ prevSample) : '0;
    irqOut = |(pending & armMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSample <= '0;
      pending    <= '0;
      armMask    <= '0;
      filtSel    <= '0;
    end else begin
      prevSample <= sample;
      // A change at the read edge survives the clear.
      pending    <= (strb.statusRd ? '0 : pending) | change;
      if (strb.armSetWr) armMask <= armMask | wdata;
      if (strb.armClrWr) armMask <= armMask & ~wdata;
      if (strb.filtWr)   filtSel <= wdata;
    end
  end

  always_comb begin
    unique case (strb.rdIdx)
      REG_ARM_MASK: rdata = armMask;
      REG_PENDING:  rdata = pending;
      REG_FILT_SEL: rdata = filtSel;
      REG_PIN_LVL:  rdata = sample;
      default:      rdata = '0;
    endcase
  end

  // R1: no flag appears while detection is still warming up
  p_warm_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.detectEn |=> pending == '0);

  // R2: every bit written to arm-set is armed afterwards
  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.armSetWr |=> (armMask & $past(wdata)) == $past(wdata));

  // R3: every bit written to arm-clear is disarmed afterwards
  p_mask_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.armClrWr |=> (armMask & $past(wdata)) == '0);

  // R4: without a read, pending flags never drop
  p_pending_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statusRd |=> (pending & $past(pending)) == $past(pending));

  // R5: nothing armed means no interrupt
  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    armMask == '0 |-> !irqOut);

  // R6, R7: after a read only freshly detected changes remain
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.statusRd |=> (pending & ~$past(change)) == '0);

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pci_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int STABLE_CLKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] pinIn,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [2:0]       busAddr,
  input  logic [LINES-1:0] busWdata,
  output logic [LINES-1:0] busRdata,
  output logic             irqOut
);
  ctrlStrobes_t strb;

  pci_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strb    (strb)
  );

  pci_datapath #(.LINES(LINES), .STABLE_CLKS(STABLE_CLKS)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn (pinIn),
    .wdata (busWdata),
    .strb  (strb),
    .rdata (busRdata),
    .irqOut(irqOut)
  );

endmodule

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  localparam int LINES = 32;
  localparam int FILT  = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LINES-1:0] pinIn = '0;
  logic             busSel = 1'b0;
  logic             busWrite = 1'b0;
  logic [2:0]       busAddr = '0;
  logic [LINES-1:0] busWdata = '0;
  logic [LINES-1:0] busRdata;
  logic             irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [LINES-1:0] expMask = '0, expPend = '0, expFilt = '0;
  logic [LINES-1:0] rd;

  always #10 clk = ~clk;

  pin_change_irq #(.LINES(LINES), .STABLE_CLKS(FILT)) u_pin_change_irq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic expIrq(input logic [LINES-1:0] p, input logic [LINES-1:0] m);
    return |(p & m);
  endfunction

  task automatic chk(input string req, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [2:0] a, input logic [LINES-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [LINES-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPins(input logic [LINES-1:0] v);
    @(negedge clk);
    expPend = expPend | (pinIn ^ v);
    pinIn = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: lines already high during reset
    pinIn = 32'hA5A5_0F0F;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(8);
    chk("R1 irq after reset", {31'b0, irqOut}, '0);
    busRd(3'd2, rd); chk("R1 mask reset", rd, '0);
    busRd(3'd4, rd); chk("R1 filter select reset", rd, '0);
    busRd(3'd3, rd); chk("R1 no false pending", rd, '0);
    busRd(3'd5, rd); chk("R9 level after reset", rd, 32'hA5A5_0F0F);

    // R2 / R3: set and clear leave zero bits untouched
    busWr(3'd0, 32'h0000_00F0);
    busWr(3'd0, 32'h0000_0F00);
    busRd(3'd2, rd); chk("R2 arm-set accumulates", rd, 32'h0000_0FF0);
    busWr(3'd1, 32'h0000_0180);
    busRd(3'd2, rd); chk("R3 arm-clear selective", rd, 32'h0000_0E70);
    busWr(3'd1, 32'hFFFF_FFFF);
    expMask = '0;

    // R4 / R5: exact latency on a plain line, flag set while unarmed
    busWr(3'd0, 32'h0000_0001); expMask = 32'h1;
    @(negedge clk); pinIn[0] = ~pinIn[0];
    @(negedge clk); chk("R4 not yet after edge k", {31'b0, irqOut}, '0);
    @(negedge clk); chk("R4 not yet after edge k+1", {31'b0, irqOut}, '0);
    @(negedge clk); chk("R4 flagged after edge k+2", {31'b0, irqOut}, 32'h1);
    @(negedge clk); pinIn[6] = ~pinIn[6];
    idle(5);
    busRd(3'd3, rd); chk("R4 unarmed line flagged", rd, 32'h0000_0041);
    chk("R6 cleared after read", {31'b0, irqOut}, '0);
    busRd(3'd3, rd); chk("R6 empty on second read", rd, '0);

    // R7: change detected at the read edge survives
    @(negedge clk); pinIn[5] = ~pinIn[5];
    idle(5);
    @(negedge clk); pinIn[0] = ~pinIn[0];
    @(negedge clk);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 3'd3;
    #1 rd = busRdata;
    @(negedge clk); busSel = 1'b0;
    chk("R7 read returns older flag only", rd, 32'h0000_0020);
    busRd(3'd3, rd); chk("R7 new flag kept", rd, 32'h0000_0001);

    // R8: debounce latency and pulse rejection
    busWr(3'd4, 32'h0000_0008); expFilt = 32'h8;
    busRd(3'd4, rd); chk("R8 select readback", rd, 32'h8);
    busWr(3'd1, 32'hFFFF_FFFF);
    busWr(3'd0, 32'h0000_0008); expMask = 32'h8;
    @(negedge clk); pinIn[3] = ~pinIn[3];
    repeat (2 + FILT) @(negedge clk);
    chk("R8 still held back", {31'b0, irqOut}, '0);
    @(negedge clk);
    chk("R8 passed after hold", {31'b0, irqOut}, 32'h1);
    busRd(3'd3, rd);
    @(negedge clk); pinIn[3] = ~pinIn[3]; pinIn[4] = ~pinIn[4];
    repeat (FILT - 1) @(negedge clk);
    pinIn[3] = ~pinIn[3]; pinIn[4] = ~pinIn[4];
    idle(10);
    busRd(3'd3, rd); chk("R8 short pulse rejected on debounced line", rd, 32'h0000_0010);
    @(negedge clk); pinIn[3] = ~pinIn[3];
    repeat (FILT) @(negedge clk);
    pinIn[3] = ~pinIn[3];
    idle(12);
    busRd(3'd3, rd); chk("R8 pulse of hold length passes", rd, 32'h0000_0008);
    busRd(3'd5, rd); chk("R9 level readback", rd, pinIn);
    expPend = '0;

    // Random steps: levels, masks, selects
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin
          logic [LINES-1:0] v; v = $urandom();
          busWr(3'd0, v); expMask = expMask | v;
        end
        1: begin
          logic [LINES-1:0] v; v = $urandom();
          busWr(3'd1, v); expMask = expMask & ~v;
        end
        2: begin
          logic [LINES-1:0] v; v = $urandom();
          busWr(3'd4, v); expFilt = v;
        end
        default: begin
          logic [LINES-1:0] v; v = pinIn ^ ($urandom() & $urandom());
          setPins(v);
        end
      endcase
      idle(FILT + 6);
      chk("R5 irq vs model", {31'b0, irqOut}, {31'b0, expIrq(expPend, expMask)});
      if (it % 7 == 3) begin
        busRd(3'd2, rd); chk("R2 mask vs model", rd, expMask);
        busRd(3'd5, rd); chk("R9 level vs model", rd, pinIn);
      end
      if (it % 5 == 4) begin
        busRd(3'd3, rd); chk("R6 pending vs model", rd, expPend);
        expPend = '0;
      end
    end
    busRd(3'd4, rd); chk("R8 select vs model", rd, expFilt);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule